// File: doc/BRIEF.md
# Three-Wire Serial Shift Unit

This block moves one byte at a time over a synchronous link made of a serial clock, a data output and a data input. It runs in one of two roles. As master, software makes the serial clock by writing a toggle bit in the control register, and each write flips the clock output once. As slave, the edges come from an external serial clock pin, which is synchronized into the system clock domain first. A 4-bit counter counts every clock edge, whether rising or falling. After sixteen edges, which is eight clock pulses, the counter wraps to zero and raises a sticky overflow flag. That flag can drive an interrupt.

Two clock modes decide which edge samples and which edge shifts. In mode 0 the clock idles low, the data input is sampled on the rising edge, and the register shifts on the falling edge. In mode 1 the clock idles high, sampling happens on the falling edge, and shifting happens on the rising edge. The sampled bit is held in a one-bit latch and enters the least significant end on the shifting edge. The byte leaves most significant bit first. After the eighth pulse the register holds the whole received byte.

The transfer tracker is a three-state machine. In `ST_IDLE` the counter is zero and the flag is clear. In `ST_XFER` edges are being counted. In `ST_DONE` the flag is set. The transitions are as follows. START goes from `ST_IDLE` to `ST_XFER` on any counted edge. WRAP goes from `ST_XFER` to `ST_DONE` on the edge that takes the counter from 15 to 0. CLEAR goes from any state to `ST_IDLE` on a status write with the flag bit set. In `ST_DONE` further edges keep counting and shifting, and the state stays `ST_DONE`.

The register port has three registers. Address 0 is the data register. Address 1 is control: bit 0 selects master, bit 1 selects clock mode, bit 2 enables the interrupt, and bit 3 is the toggle strobe, which reads as 0. Address 2 is status: bit 7 is the flag and bits 3:0 are the counter. Address 3 reads as 0.

Top module: `ser3w_shift_unit`

## Requirements
- R1: After reset the data register, the counter and the flag read as 0, and `sclk_out`, `sdo` and `irq` are low.
- R2: A write to address 0 loads the byte. From the next cycle `sdo` shows bit 7 of that byte, and a write takes priority over a shift in the same cycle.
- R3: In mode 0 (control bit 1 = 0), `sdi` is captured on rising edges and the register shifts left on falling edges. Eight pulses exchange the two bytes in full duplex, MSB first.
- R4: In mode 1 (control bit 1 = 1), the clock idles high, `sdi` is captured on falling edges, and the register shifts on rising edges. Eight pulses give the same full-duplex exchange.
- R5: In master mode, a control write with bit 3 = 1 inverts `sclk_out` and counts as one edge. A control write with bit 3 = 0 sets `sclk_out` to the idle level of the written mode and counts no edge.
- R6: The counter in status bits 3:0 goes up by one on every counted edge, rising or falling.
- R7: The flag in status bit 7 stays clear through 15 edges. It is set, and the counter reads 0, after exactly the 16th edge.
- R8: A status write with bit 7 = 1 clears both the flag and the counter. A status write with bit 7 = 0 changes neither.
- R9: `irq` is high exactly when the flag is set and control bit 2 is 1.
- R10: In slave mode (control bit 0 = 0), edges are taken from `sclk_in` after a two-flop synchronizer, and the exchange of R3 and R4 holds.
- R11: In master mode, transitions on `sclk_in` are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| sclk_in | input | 1 | External serial clock (slave mode) |
| sclk_out | output | 1 | Serial clock driven in master mode |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output |
| irq | output | 1 | Overflow interrupt request |

## Verification
The assertions assume that `sclk_in` and `sdi` hold each level for several system clocks. This lets the synchronizer deliver one clean edge per transition, with `sdi` settled before the matching sampling edge. They also assume that software does not issue a toggle write in the same cycle as a status clear. The stimulus meets these assumptions by holding each serial level for six system cycles. It changes the peer's data bit only after the shifting edge has been seen, and it spaces every register access by at least one idle cycle.

// File: rtl/ser3w_pkg.sv
package ser3w_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_DONE = 2'd2
    } xfer_state_t;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    localparam int CTL_MASTER = 0;
    localparam int CTL_MODE   = 1;
    localparam int CTL_IRQEN  = 2;
    localparam int CTL_TOGGLE = 3;
endpackage

// File: rtl/ser3w_sync.sv
module ser3w_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/ser3w_edge.sv
module ser3w_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic master,
    input  logic tgl,
    input  logic sclk_lvl,
    input  logic sclk_sync,
    output logic rise,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sclk_sync;
    end

    always_comb begin
        if (master) begin
            rise = tgl & ~sclk_lvl;
            fall = tgl &  sclk_lvl;
        end else begin
            rise =  sclk_sync & ~prev_q;
            fall = ~sclk_sync &  prev_q;
        end
    end

    assert_pin_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (master && !tgl) |-> (!rise && !fall));
endmodule

// File: rtl/ser3w_core.sv
module ser3w_core
    import ser3w_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = $clog2(2 * DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode,
    input  logic              rise,
    input  logic              fall,
    input  logic              sdi_s,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              clr,
    output logic [DATA_W-1:0] shreg,
    output logic [CNT_W-1:0]  cnt,
    output logic              flag
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    xfer_state_t state_q, state_d;
    logic        edge_any, edge_smp, edge_sft;
    logic        bit_latch;

    assign edge_any = rise | fall;
    assign edge_smp = mode ? fall : rise;
    assign edge_sft = mode ? rise : fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (clr)           state_d = ST_IDLE;
                else if (edge_any) state_d = ST_XFER;
            end
            ST_XFER: begin
                if (clr)                              state_d = ST_IDLE;
                else if (edge_any && cnt == CNT_MAX)  state_d = ST_DONE;
            end
            ST_DONE: begin
                if (clr) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign flag = (state_q == ST_DONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (clr)      cnt <= '0;
        else if (edge_any) cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        bit_latch <= 1'b0;
        else if (edge_smp) bit_latch <= sdi_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        shreg <= '0;
        else if (load)     shreg <= load_data;
        else if (edge_sft) shreg <= {shreg[DATA_W-2:0], bit_latch};
    end

    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (cnt == '0));
    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_any && !clr) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
    assert_flag_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ($past(edge_any) && $past(cnt) == CNT_MAX));
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0 && !flag));
endmodule

// File: rtl/ser3w_shift_unit.sv
module ser3w_shift_unit
    import ser3w_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              sclk_in,
    output logic              sclk_out,
    input  logic              sdi,
    output logic              sdo,
    output logic              irq
);
    localparam int CNT_W    = $clog2(2 * DATA_W);
    localparam int FLAG_BIT = DATA_W - 1;

    logic master_q, mode_q, irqen_q;
    logic wr_data_reg, wr_ctrl, wr_stat, tgl, clr;
    logic sclk_s, sdi_s, rise, fall, flag;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic [1:0]        sync_q;

    assign wr_data_reg = wr_en && (wr_addr == ADDR_DATA);
    assign wr_ctrl     = wr_en && (wr_addr == ADDR_CTRL);
    assign wr_stat     = wr_en && (wr_addr == ADDR_STAT);
    assign tgl         = wr_ctrl && wr_data[CTL_TOGGLE] && wr_data[CTL_MASTER];
    assign clr         = wr_stat && wr_data[FLAG_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            master_q <= 1'b0;
            mode_q   <= 1'b0;
            irqen_q  <= 1'b0;
            sclk_out <= 1'b0;
        end else if (wr_ctrl) begin
            master_q <= wr_data[CTL_MASTER];
            mode_q   <= wr_data[CTL_MODE];
            irqen_q  <= wr_data[CTL_IRQEN];
            sclk_out <= wr_data[CTL_TOGGLE] ? ~sclk_out : wr_data[CTL_MODE];
        end
    end

    ser3w_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({sclk_in, sdi}),
        .q    (sync_q)
    );
    assign sclk_s = sync_q[1];
    assign sdi_s  = sync_q[0];

    ser3w_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .master   (master_q),
        .tgl      (tgl),
        .sclk_lvl (sclk_out),
        .sclk_sync(sclk_s),
        .rise     (rise),
        .fall     (fall)
    );

    ser3w_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_q),
        .rise     (rise),
        .fall     (fall),
        .sdi_s    (sdi_s),
        .load     (wr_data_reg),
        .load_data(wr_data),
        .clr      (clr),
        .shreg    (shreg),
        .cnt      (cnt),
        .flag     (flag)
    );

    assign sdo = shreg[DATA_W-1];
    assign irq = flag & irqen_q;

    always_comb begin
        unique case (rd_addr)
            ADDR_DATA: rd_data = shreg;
            ADDR_CTRL: rd_data = {{(DATA_W-3){1'b0}}, irqen_q, mode_q, master_q};
            ADDR_STAT: rd_data = {flag, {(DATA_W-1-CNT_W){1'b0}}, cnt};
            default:   rd_data = '0;
        endcase
    end

    assert_sdo_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data_reg |=> (sdo == $past(wr_data[DATA_W-1])));
    assert_irq_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !irq);
    assert_sclk_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(sclk_out));
endmodule

// File: tb/sim_ser3w_shift_unit.sv
module sim_ser3w_shift_unit;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n, wr_en, sclk_in, sdi;
    logic [1:0] wr_addr, rd_addr;
    logic [7:0] wr_data, rd_data;
    logic       sclk_out, sdo, irq;

    int n_chk = 0;
    int n_err = 0;

    ser3w_shift_unit u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .sclk_in(sclk_in), .sclk_out(sclk_out), .sdi(sdi), .sdo(sdo), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic serial_edge(input bit master, input bit mode, input bit lvl);
        if (master) wr(2'd1, {4'b0000, 1'b1, 1'b1, mode, 1'b1});
        else begin
            @(negedge clk);
            sclk_in = lvl;
        end
        idle(6);
    endtask

    task automatic xfer(input bit master, input bit mode, input logic [7:0] dut_tx,
                        input logic [7:0] peer_tx);
        logic [7:0] peer_sr, st, dv;
        logic       rx_bit;
        string      tg;
        tg = !master ? "R10" : (mode ? "R4" : "R3");
        wr(2'd1, {5'b00001, 1'b1, mode, 1'b1});
        sclk_in = mode;
        idle(6);
        wr(2'd1, {5'b00000, 1'b1, mode, master});
        wr(2'd2, 8'h80);
        wr(2'd0, dut_tx);
        chk(sdo == dut_tx[7], "R2 sdo after load", sdo, dut_tx[7]);
        peer_sr = peer_tx;
        sdi = peer_sr[7];
        for (int k = 0; k < 8; k++) begin
            idle(5);
            rx_bit = sdo;
            serial_edge(master, mode, ~mode);
            rd(2'd2, st);
            chk(st == 8'(2*k+1), "R6 count after leading edge", st, 2*k+1);
            serial_edge(master, mode, mode);
            rd(2'd2, st);
            if (k < 7) chk(st == 8'(2*k+2), "R7 count/flag before 16th edge", st, 2*k+2);
            else       chk(st == 8'h80, "R7 flag at 16th edge", st, 8'h80);
            peer_sr = {peer_sr[6:0], rx_bit};
            sdi = peer_sr[7];
        end
        rd(2'd0, dv);
        chk(dv == peer_tx, {tg, " received byte"}, dv, peer_tx);
        chk(peer_sr == dut_tx, {tg, " transmitted byte"}, peer_sr, dut_tx);
        chk(irq == 1'b1, "R9 irq with flag and enable", irq, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        sclk_in = 1'b0; sdi = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(2'd0, v); chk(v == 8'h00, "R1 data reset", v, 0);
        rd(2'd2, v); chk(v == 8'h00, "R1 status reset", v, 0);
        chk(sclk_out == 1'b0, "R1 sclk_out reset", sclk_out, 0);
        chk(sdo == 1'b0, "R1 sdo reset", sdo, 0);
        chk(irq == 1'b0, "R1 irq reset", irq, 0);

        // R5 toggle and idle-level writes
        wr(2'd1, 8'h01);
        wr(2'd1, 8'h09);
        rd(2'd2, v);
        chk(sclk_out == 1'b1, "R5 toggle flips sclk_out", sclk_out, 1);
        chk(v == 8'h01, "R5 toggle counts one edge", v, 1);
        wr(2'd1, 8'h03);
        rd(2'd2, v);
        chk(sclk_out == 1'b1, "R5 idle level mode 1", sclk_out, 1);
        chk(v == 8'h01, "R5 plain write counts no edge", v, 1);
        wr(2'd1, 8'h01);
        rd(2'd2, v);
        chk(sclk_out == 1'b0, "R5 idle level mode 0", sclk_out, 0);
        chk(v == 8'h01, "R5 plain write counts no edge", v, 1);
        wr(2'd2, 8'h80);

        // R11 pin ignored in master mode
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); sclk_in = ~sclk_in;
            idle(6);
        end
        rd(2'd2, v);
        chk(v == 8'h00, "R11 sclk_in not counted", v, 0);

        // Sweep: role x mode x byte patterns
        for (int m = 0; m < 2; m++)
            for (int md = 0; md < 2; md++)
                for (int i = 0; i < 16; i++)
                    xfer(m[0], md[0], 8'(i*37 + 5), 8'(~(i*53)));
        xfer(1'b1, 1'b0, 8'h00, 8'hFF);
        xfer(1'b0, 1'b1, 8'hFF, 8'h00);

        // R9 mask, R8 write-zero and clear
        wr(2'd1, 8'h03);
        chk(irq == 1'b0, "R9 irq masked", irq, 0);
        wr(2'd2, 8'h00);
        rd(2'd2, v);
        chk(v == 8'h80, "R8 write 0 keeps flag", v, 8'h80);
        wr(2'd1, 8'h07);
        chk(irq == 1'b1, "R9 irq re-enabled", irq, 1);
        wr(2'd2, 8'h80);
        rd(2'd2, v);
        chk(v == 8'h00, "R8 clear flag and count", v, 0);
        chk(irq == 1'b0, "R9 irq after clear", irq, 0);
        for (int i = 0; i < 3; i++) serial_edge(1'b1, 1'b1, 1'b0);
        rd(2'd2, v);
        chk(v == 8'h03, "R6 partial count", v, 3);
        wr(2'd2, 8'h80);
        rd(2'd2, v);
        chk(v == 8'h00, "R8 mid-transfer clear", v, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule